// File: doc/BRIEF.md
# Single-bit NAND ECC compare and correct

This block checks one data chunk of a NAND page against the single-error-correcting code that was stored with it, and repairs one bit of the chunk in place when the mismatch allows it. The parity generator that watched the data stream supplies a raw 32-bit ECC word. The block keeps two 12-bit parity halves from that word and inverts them to form a 24-bit code. With this inversion an erased page, which holds all ones in both data and spare area, checks clean.

A start pulse captures the raw word and the 24-bit code read back from the spare area. The block XORs the computed code with the stored code and classifies the difference:
- no error;
- a single data-bit error, which the block fixes;
- a single-bit error in the stored code itself, which needs no data change;
- an uncorrectable pattern.

For a data-bit error the block runs one read-modify-write on the byte-addressed chunk buffer. It reads the byte, toggles the bit and writes the byte back. A one-cycle done pulse then reports a 2-bit status, and that status holds until the next operation decides.

The buffer port is a plain synchronous memory port with no back-pressure. Read data must be valid in the cycle after `mem_rd_en`, and a write takes effect at the clock edge where `mem_wr_en` is high.

Top module: `nsec_fix`

## Requirements
- R1: The computed code is bits [11:0] of the raw word in code bits [11:0] and bits [27:16] of the raw word in code bits [23:12], with every bit inverted. It is shown on `calc_code` with code byte 0 in bits [7:0], byte 1 in [15:8] and byte 2 in [23:16]. The stored code uses the same byte order. A raw word of zero with a stored code of 0xFFFFFF reports no error.
- R2: When the difference (computed XOR stored) is zero, status is 0 (none) and the buffer is not written.
- R3: When difference bits [23:12] XOR difference bits [11:0] equal 0xFFF and the byte offset difference[23:15] is below CHUNK_BYTES, the block toggles bit difference[14:12] of that byte and reports status 1 (corrected).
- R4: A difference that matches the R3 pattern but has a byte offset of CHUNK_BYTES or more reports status 2 (uncorrectable) and leaves the buffer untouched.
- R5: A difference with exactly one bit set reports status 1 (corrected) and does not write the buffer.
- R6: Any other nonzero difference reports status 2 (uncorrectable) with no buffer write.
- R7: `done` is a single-cycle pulse. It is high in the second cycle after the start cycle when no write is needed, and in the fourth cycle when a repair is done, which is one cycle after the write cycle. `status` is valid with `done` and holds afterwards until the next operation decides.
- R8: `busy` is high from the cycle after a start until the end of the done cycle. A start that arrives while `busy` is high is ignored and does not alter the running operation or `calc_code`.
- R9: After reset, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are 0 and `status` is 0.
- R10: A repair drives `mem_rd_en` for one cycle, then `mem_wr_en` for one cycle at the same `mem_addr`. The write data is the byte returned by the read with the one bit toggled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check; sampled only while idle |
| raw_ecc | input | RAW_W (32) | Raw parity word from the ECC generator |
| stored_code | input | 2*HALF_W (24) | Code read from spare area, byte 0 in [7:0] |
| calc_code | output | 2*HALF_W (24) | Captured computed code, byte 0 in [7:0] |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 none, 1 corrected, 2 uncorrectable |
| mem_addr | output | log2(CHUNK_BYTES) | Byte address for the repair |
| mem_rd_en | output | 1 | Buffer read request |
| mem_rd_data | input | 8 | Buffer read data, valid one cycle after the request |
| mem_wr_en | output | 1 | Buffer write strobe |
| mem_wr_data | output | 8 | Repaired byte |

## Verification
The only results with a deadline are the done pulse and the status. `done` is due two cycles after the start cycle when no write is needed and four cycles after it when a repair is made. The bench drives each start on a falling edge and counts falling edges until `done` is high. It compares that count with the latency the vector expects, so an early or a late pulse both fail. The status, the computed code and the whole buffer are compared on the done cycle, and `done` is checked to have fallen one cycle later.

// File: rtl/nsec_pkg.sv
package nsec_pkg;
  typedef enum logic [1:0] {
    ST_NONE  = 2'd0,
    ST_FIXED = 2'd1,
    ST_BAD   = 2'd2
  } nsec_status_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DECIDE,
    PH_READ,
    PH_WRITE,
    PH_DONE
  } nsec_phase_e;
endpackage

// File: rtl/nsec_code_build.sv
module nsec_code_build #(
  parameter int RAW_W  = 32,
  parameter int HALF_W = 12,
  parameter int HI_LSB = 16
) (
  input  logic [RAW_W-1:0]    raw,
  output logic [2*HALF_W-1:0] code
);
  logic unused_raw;
  assign unused_raw = ^raw;
  // two parity halves joined, inverted so erased pages compare equal
  assign code = ~{raw[HI_LSB+HALF_W-1:HI_LSB], raw[HALF_W-1:0]};
endmodule

// File: rtl/nsec_classify.sv
module nsec_classify #(
  parameter int HALF_W      = 12,
  parameter int CHUNK_BYTES = 512,
  localparam int CODE_W     = 2*HALF_W,
  localparam int OFF_W      = HALF_W-3
) (
  input  logic [CODE_W-1:0] diff,
  output logic              is_zero,
  output logic              fix_ok,
  output logic              code_only,
  output logic [OFF_W-1:0]  off,
  output logic [2:0]        bitx
);
  logic pair_ok;
  logic in_range;

  assign pair_ok   = ((diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0]) == {HALF_W{1'b1}});
  assign off       = diff[CODE_W-1:HALF_W+3];
  assign bitx      = diff[HALF_W+2:HALF_W];
  assign in_range  = (32'(off) < CHUNK_BYTES);
  assign is_zero   = (diff == '0);
  assign fix_ok    = pair_ok && in_range;
  assign code_only = !pair_ok && $onehot(diff);
endmodule

// File: rtl/nsec_seq.sv
module nsec_seq
  import nsec_pkg::*;
#(
  parameter int OFF_W  = 9,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_zero,
  input  logic              fix_ok,
  input  logic              code_only,
  input  logic [OFF_W-1:0]  off,
  input  logic [2:0]        bitx,
  output logic              capture,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_en,
  output logic [7:0]        mem_wr_data
);
  nsec_phase_e  ph_q;
  nsec_status_e status_q;
  logic         unused_off;

  assign unused_off  = ^off;
  assign capture     = start && (ph_q == PH_IDLE);
  assign busy        = (ph_q != PH_IDLE);
  assign done        = (ph_q == PH_DONE);
  assign mem_rd_en   = (ph_q == PH_READ);
  assign mem_wr_en   = (ph_q == PH_WRITE);
  assign mem_addr    = off[ADDR_W-1:0];
  assign mem_wr_data = mem_rd_data ^ 8'(8'd1 << bitx);
  assign status      = status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      status_q <= ST_NONE;
    end else begin
      unique case (ph_q)
        PH_IDLE:   if (start) ph_q <= PH_DECIDE;
        PH_DECIDE: begin
          if (is_zero)                 status_q <= ST_NONE;
          else if (fix_ok || code_only) status_q <= ST_FIXED;
          else                         status_q <= ST_BAD;
          ph_q <= fix_ok ? PH_READ : PH_DONE;
        end
        PH_READ:   ph_q <= PH_WRITE;
        PH_WRITE:  ph_q <= PH_DONE;
        PH_DONE:   ph_q <= PH_IDLE;
        default:   ph_q <= PH_IDLE;
      endcase
    end
  end

  // R10: a write always follows the read of the same byte
  assert_wr_after_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($past(mem_rd_en) && $stable(mem_addr)));
  // R7: done lasts a single cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: done comes one cycle after the write
  assert_write_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> done);
  // R8: busy drops right after the done cycle
  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/nsec_fix.sv
module nsec_fix #(
  parameter int RAW_W       = 32,
  parameter int HALF_W      = 12,
  parameter int HI_LSB      = 16,
  parameter int CHUNK_BYTES = 512,
  localparam int CODE_W     = 2*HALF_W,
  localparam int OFF_W      = HALF_W-3,
  localparam int ADDR_W     = $clog2(CHUNK_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RAW_W-1:0]  raw_ecc,
  input  logic [CODE_W-1:0] stored_code,
  output logic [CODE_W-1:0] calc_code,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_en,
  output logic [7:0]        mem_wr_data
);
  logic [CODE_W-1:0] code_now;
  logic [CODE_W-1:0] calc_q;
  logic [CODE_W-1:0] stored_q;
  logic [CODE_W-1:0] diff;
  logic              capture;
  logic              is_zero, fix_ok, code_only;
  logic [OFF_W-1:0]  off;
  logic [2:0]        bitx;

  nsec_code_build #(.RAW_W(RAW_W), .HALF_W(HALF_W), .HI_LSB(HI_LSB)) u_build (
    .raw(raw_ecc), .code(code_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      calc_q   <= '0;
      stored_q <= '0;
    end else if (capture) begin
      calc_q   <= code_now;
      stored_q <= stored_code;
    end
  end

  assign diff      = calc_q ^ stored_q;
  assign calc_code = calc_q;

  nsec_classify #(.HALF_W(HALF_W), .CHUNK_BYTES(CHUNK_BYTES)) u_class (
    .diff(diff), .is_zero(is_zero), .fix_ok(fix_ok), .code_only(code_only),
    .off(off), .bitx(bitx)
  );

  nsec_seq #(.OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .is_zero(is_zero), .fix_ok(fix_ok), .code_only(code_only),
    .off(off), .bitx(bitx), .capture(capture),
    .busy(busy), .done(done), .status(status),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data)
  );

  // R8: a start seen while busy leaves the captured code alone
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(calc_code));
  // R2: a clean compare never reaches the buffer write
  assert_clean_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_zero) |-> !mem_wr_en);
endmodule

// File: tb/nsec_fix_test.sv
module nsec_fix_test;
  localparam int CLK_PERIOD = 10;
  localparam int CHUNK = 256;
  localparam int NV = 9;

  localparam logic [31:0] V_RAW [NV] = '{32'h0000_0000, 32'h0ABC_0123, 32'hFFFF_FFFF,
    32'h1234_5678, 32'h5A5A_A5A5, 32'h0F0F_F0F0, 32'hDEAD_BEEF, 32'h0000_0001, 32'hC0DE_0042};
  localparam logic [23:0] V_DIFF [NV] = '{24'h000000, 24'h02BFD4, 24'h7FF800,
    24'h000FFF, 24'h8007FF, 24'h000400, 24'h800000, 24'h000003, 24'hFFFFFF};
  localparam logic [1:0] V_ST [NV] = '{2'd0, 2'd1, 2'd1, 2'd1, 2'd2, 2'd1, 2'd1, 2'd2, 2'd2};
  localparam logic V_WR [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] raw_ecc = '0;
  logic [23:0] stored_code = '0, calc_code;
  logic busy, done, mem_rd_en, mem_wr_en;
  logic [1:0] status;
  logic [7:0] mem_addr, mem_rd_data, mem_wr_data;
  logic [7:0] mem [CHUNK];
  logic [7:0] model [CHUNK];
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nsec_fix #(.CHUNK_BYTES(CHUNK)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .raw_ecc(raw_ecc),
    .stored_code(stored_code), .calc_code(calc_code), .busy(busy), .done(done),
    .status(status), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CHUNK; i++) mem[i] <= 8'(i*7 + 3);
      mem_rd_data <= '0;
    end else begin
      if (mem_rd_en) mem_rd_data <= mem[mem_addr];
      if (mem_wr_en) mem[mem_addr] <= mem_wr_data;
    end
  end

  function automatic logic [23:0] calc_of(logic [31:0] r);
    return ~{r[27:16], r[11:0]};
  endfunction

  function automatic string req_of(int i);
    case (i)
      0: return "R2";
      1, 2, 3: return "R3";
      4: return "R4";
      5, 6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(logic [31:0] raw, logic [23:0] dif, logic [1:0] est,
                        logic ewr, string req, bit poke);
    int lat;
    int mism;
    logic [23:0] st;
    st = calc_of(raw) ^ dif;
    @(negedge clk);
    raw_ecc = raw; stored_code = st; start = 1;
    lat = 0;
    while (lat < 12) begin
      @(negedge clk);
      lat++;
      if (poke && lat == 1) begin
        raw_ecc = 32'h1357_9BDF; stored_code = 24'h123456; start = 1;
      end else start = 0;
      if (done) break;
    end
    if (ewr) model[dif[23:15]] = model[dif[23:15]] ^ 8'(8'd1 << dif[14:12]);
    check("R7", "done latency", lat, ewr ? 4 : 2);
    check(req, "status", {30'd0, status}, {30'd0, est});
    check("R1", "calc_code", {8'd0, calc_code}, {8'd0, calc_of(raw)});
    mism = 0;
    for (int i = 0; i < CHUNK; i++) if (mem[i] !== model[i]) mism++;
    check(req, "buffer mismatches", mism, 0);
    @(negedge clk);
    check("R7", "done fell", {31'd0, done}, 0);
    check("R8", "busy fell", {31'd0, busy}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < CHUNK; i++) model[i] = 8'(i*7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9", "busy", {31'd0, busy}, 0);
    check("R9", "done", {31'd0, done}, 0);
    check("R9", "status", {30'd0, status}, 0);
    check("R9", "rd/wr", {30'd0, mem_rd_en, mem_wr_en}, 0);

    for (int v = 0; v < NV; v++)
      run_op(V_RAW[v], V_DIFF[v], V_ST[v], V_WR[v], req_of(v), 1'b0);

    // R7: status holds after done
    repeat (3) @(negedge clk);
    check("R7", "status held", {30'd0, status}, 2);

    // R8: second start during a repair (offset 10, bit 6) is ignored
    run_op(32'h0000_0000, 24'h056FA9, 2'd1, 1'b1, "R8", 1'b1);

    // R10: read strobe then write strobe at same address, toggled data
    @(negedge clk);
    raw_ecc = 32'h0000_0000; stored_code = calc_of(32'h0) ^ 24'h0C8F37; start = 1; // offset 25 bit 0
    @(negedge clk); start = 0;                               // decide cycle
    @(negedge clk);
    check("R10", "read strobe", {31'd0, mem_rd_en}, 1);
    check("R10", "read addr", {24'd0, mem_addr}, 25);
    @(negedge clk);
    check("R10", "write strobe", {31'd0, mem_wr_en}, 1);
    check("R10", "write data", {24'd0, mem_wr_data}, {24'd0, model[25] ^ 8'h01});
    model[25] = model[25] ^ 8'h01;
    @(negedge clk);
    check("R10", "done after write", {31'd0, done}, 1);
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule